// File: doc/BRIEF.md
# UART Interrupt Prioritizer with Receive Timeout

This block produces the interrupt status of one UART channel. Each cycle it takes the receive FIFO fill level and its trigger level, the pending line-status error and modem-status change flags, the transmit-holding-empty flag and the four interrupt enables. It reports the one pending source with the highest priority as a 4-bit identifier, and it drives an interrupt request line. Both outputs are registered, so a change at the inputs shows up one clock later.

The block also contains the receive timeout counter. It counts half-bit ticks from the baud generator while the receive FIFO holds data. It fires after four character times, where a character time is the start bit, the programmed data bits, the optional parity bit and 1, 1.5 or 2 stop bits. The count restarts on every received stop-bit centre and on every read of the receive holding register. FIFO storage, the serializer and the register bus live elsewhere. Reading the identifier is the job of the surrounding register file.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While rst_ni is low, irq_id_o is 4'b0001 (nothing pending) and irq_o is 0.
- R2: One character time is 2*(1 + D + P) + S half-bit ticks. D is the data width (word_len_i 00..11 gives 5..8 bits), P is parity_en_i and S is the stop length in half bits. With the FIFO non-empty and no restart, the timeout becomes pending on exactly the 4×(character time)-th half_tick_i pulse and not on the one before it.
- R3: stop_sel_i selects the stop length: 00 is one bit (S=2), 01 is one and a half bits (S=3), and 10 or 11 is two bits (S=4).
- R4: A pulse on stop_center_i or rhr_read_i clears the timeout count to zero, which removes a pending timeout.
- R5: No timeout is pending while rx_level_i is 0. The count is held at zero then, and counting starts from zero once data arrives.
- R6: Receive-data-ready (rx_level_i >= rx_trig_i, identifier 4'b0100) and receive timeout (identifier 4'b1100) share one priority level, and both are enabled by ier_i[0]. When both are pending, data-ready is reported.
- R7: The fixed priority order, highest first, is: line-status error (ier_i[2], identifier 4'b0110), then the receive pair, then transmit-holding-empty (ier_i[1], identifier 4'b0010), then modem-status change (ier_i[3], identifier 4'b0000). Only the winner is reported.
- R8: With ier_i[1] set and thr_empty_i high, the transmit-holding-empty interrupt is reported in the first cycle after reset is released.
- R9: irq_o is 1 exactly when irq_id_o is not 4'b0001.
- R10: A source whose enable bit is 0 has no effect on irq_id_o or irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_tick_i | input | 1 | One-cycle pulse every half bit time |
| word_len_i | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| parity_en_i | input | 1 | Frame carries a parity bit |
| stop_sel_i | input | 2 | Stop length: 00=1, 01=1.5, 1x=2 bits |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_trig_i | input | LVL_W | Receive trigger level |
| stop_center_i | input | 1 | Pulse at the centre of a received stop bit |
| rhr_read_i | input | 1 | Pulse on a receive holding register read |
| thr_empty_i | input | 1 | Transmit holding register is empty |
| line_err_i | input | 1 | A line-status error is pending |
| modem_chg_i | input | 1 | A modem-status change is pending |
| ier_i | input | 4 | Enables: [0] receive, [1] transmit empty, [2] line status, [3] modem |
| irq_id_o | output | 4 | Identifier of the highest-priority pending source |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that half_tick_i, stop_center_i and rhr_read_i are single-cycle pulses. They also assume that the frame format stays fixed while a count is running, so the count never passes its limit. The bench changes word_len_i, parity_en_i and stop_sel_i only just before a restart pulse. It drives every input a short time after the rising edge and holds it for whole cycles. It checks one cycle after the edge that registers a change, which accounts for the registered identifier.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM  = 4'b0000,
    ID_NONE   = 4'b0001,
    ID_THRE   = 4'b0010,
    ID_RXDATA = 4'b0100,
    ID_LINE   = 4'b0110,
    ID_RXTO   = 4'b1100
  } irq_id_e;

  // sources in priority order, index 0 highest
  localparam int unsigned NSRC = 5;
  localparam int unsigned IER_W = 4;
  // widest character in half bits: start + 8 data + parity, plus 2 stop bits
  localparam int unsigned CHAR_HB_MAX = 2 * (1 + 8 + 1) + 4;

  function automatic irq_id_e src_code(input int unsigned idx);
    case (idx)
      0: return ID_LINE;
      1: return ID_RXDATA;
      2: return ID_RXTO;
      3: return ID_THRE;
      default: return ID_MODEM;
    endcase
  endfunction

  function automatic int unsigned src_ier_bit(input int unsigned idx);
    case (idx)
      0: return 2;
      1, 2: return 0;
      3: return 1;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/uart_frame_span.sv
module uart_frame_span #(
  parameter int unsigned CHARS = 4,
  parameter int unsigned CNT_W = 7
) (
  input  logic [1:0]       word_len_i,
  input  logic             parity_en_i,
  input  logic [1:0]       stop_sel_i,
  output logic [CNT_W-1:0] limit_o
);

  logic [4:0] stop_hb;
  logic [4:0] char_hb;

  always_comb begin
    case (stop_sel_i)
      2'b00:   stop_hb = 5'd2;
      2'b01:   stop_hb = 5'd3;
      default: stop_hb = 5'd4;
    endcase
    // start + (5 + code) data + parity, in half bits
    char_hb = 5'd2 * (5'd6 + {3'b000, word_len_i} + {4'b0000, parity_en_i}) + stop_hb;
    limit_o = CNT_W'(CHARS) * CNT_W'(char_hb);
  end

endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             half_tick_i,
  input  logic             stop_center_i,
  input  logic             rhr_read_i,
  input  logic             fifo_nonempty_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             timeout_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             restart;

  assign restart = stop_center_i | rhr_read_i | ~fifo_nonempty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (restart)                         cnt_q <= '0;
    else if (half_tick_i && cnt_q < limit_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign timeout_o = fifo_nonempty_i && (cnt_q >= limit_i);

  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_center_i || rhr_read_i) |=> (cnt_q == '0));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_tick_i && !restart && cnt_q < limit_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half_tick_i && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  raw_i,
  input  logic [IER_W-1:0] ier_i,
  output logic [3:0]       id_o,
  output logic             irq_o
);

  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] grant;
  irq_id_e         id_d, id_q;
  logic            irq_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign pend[g] = raw_i[g] & ier_i[src_ier_bit(g)];
  end

  always_comb begin
    grant = '0;
    id_d  = ID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        id_d = src_code(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q  <= ID_NONE;
      irq_q <= 1'b0;
    end else begin
      id_q  <= id_d;
      irq_q <= |pend;
    end
  end

  assign id_o  = id_q;
  assign irq_o = irq_q;

  p_one_winner_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  p_line_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[0] |=> (id_q == ID_LINE));

  p_irq_line_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == (id_q != ID_NONE));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 8,
  parameter int unsigned CHARS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             half_tick_i,
  input  logic [1:0]       word_len_i,
  input  logic             parity_en_i,
  input  logic [1:0]       stop_sel_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic             stop_center_i,
  input  logic             rhr_read_i,
  input  logic             thr_empty_i,
  input  logic             line_err_i,
  input  logic             modem_chg_i,
  input  logic [3:0]       ier_i,
  output logic [3:0]       irq_id_o,
  output logic             irq_o
);

  localparam int unsigned CNT_W = $clog2(CHARS * CHAR_HB_MAX + 1);

  logic [CNT_W-1:0] limit;
  logic             fifo_nonempty;
  logic             rx_to;
  logic [NSRC-1:0]  raw;

  assign fifo_nonempty = |rx_level_i;

  uart_frame_span #(.CHARS(CHARS), .CNT_W(CNT_W)) u_span (
    .word_len_i  (word_len_i),
    .parity_en_i (parity_en_i),
    .stop_sel_i  (stop_sel_i),
    .limit_o     (limit)
  );

  uart_rx_timeout #(.CNT_W(CNT_W)) u_tmo (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .half_tick_i     (half_tick_i),
    .stop_center_i   (stop_center_i),
    .rhr_read_i      (rhr_read_i),
    .fifo_nonempty_i (fifo_nonempty),
    .limit_i         (limit),
    .timeout_o       (rx_to)
  );

  assign raw = {modem_chg_i, thr_empty_i, rx_to,
                fifo_nonempty && (rx_level_i >= rx_trig_i), line_err_i};

  uart_irq_arbiter u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw),
    .ier_i  (ier_i),
    .id_o   (irq_id_o),
    .irq_o  (irq_o)
  );

  p_quiet_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_i == '0) |=> (irq_id_o != ID_RXTO));

  p_rx_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_i[0] |=> (irq_id_o != ID_RXDATA && irq_id_o != ID_RXTO));

  p_off_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_i == '0) |=> !irq_o);

endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       half_tick_i = 1'b0;
  logic [1:0] word_len_i = 2'b11;
  logic       parity_en_i = 1'b0;
  logic [1:0] stop_sel_i = 2'b00;
  logic [7:0] rx_level_i = '0;
  logic [7:0] rx_trig_i = 8'd1;
  logic       stop_center_i = 1'b0;
  logic       rhr_read_i = 1'b0;
  logic       thr_empty_i = 1'b1;
  logic       line_err_i = 1'b0;
  logic       modem_chg_i = 1'b0;
  logic [3:0] ier_i = 4'b0010;
  logic [3:0] irq_id_o;
  logic       irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [3:0] NONE = 4'b0001, LINE = 4'b0110, RXD = 4'b0100,
                         RXTO = 4'b1100, THRE = 4'b0010, MODEM = 4'b0000;

  always #4 clk_i = ~clk_i;

  uart_irq_ctrl uut (.*);

  // {ier, line_err, thr_empty, modem_chg, level, trig, expected id}
  localparam int NV = 12;
  localparam logic [26:0] VEC [NV] = '{
    {4'b0000, 1'b1, 1'b1, 1'b1, 8'd10, 8'd4, NONE },
    {4'b1111, 1'b1, 1'b1, 1'b1, 8'd10, 8'd4, LINE },
    {4'b1011, 1'b1, 1'b1, 1'b1, 8'd10, 8'd4, RXD  },
    {4'b1111, 1'b0, 1'b1, 1'b1, 8'd3,  8'd4, THRE },
    {4'b1111, 1'b0, 1'b0, 1'b1, 8'd3,  8'd4, MODEM},
    {4'b1111, 1'b0, 1'b0, 1'b0, 8'd3,  8'd4, NONE },
    {4'b1111, 1'b0, 1'b0, 1'b0, 8'd4,  8'd4, RXD  },
    {4'b1110, 1'b0, 1'b0, 1'b0, 8'd4,  8'd4, NONE },
    {4'b1101, 1'b0, 1'b1, 1'b0, 8'd4,  8'd4, RXD  },
    {4'b1000, 1'b0, 1'b1, 1'b1, 8'd0,  8'd1, MODEM},
    {4'b0010, 1'b0, 1'b1, 1'b0, 8'd0,  8'd1, THRE },
    {4'b0100, 1'b1, 1'b0, 1'b0, 8'd0,  8'd1, LINE }
  };

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic htick(input int n);
    for (int i = 0; i < n; i++) begin
      half_tick_i = 1'b1;
      step();
      half_tick_i = 1'b0;
    end
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    n_cmp++;
    if (irq_id_o !== exp || irq_o !== (exp != NONE)) begin
      n_bad++;
      $display("FAIL %s: id=%b irq=%b expected id=%b irq=%b",
               req, irq_id_o, irq_o, exp, (exp != NONE));
    end
  endtask

  task automatic clear_cnt();
    rhr_read_i = 1'b1;
    step();
    rhr_read_i = 1'b0;
  endtask

  task automatic run_to(input logic [1:0] wl, input logic par, input logic [1:0] st,
                        input int n, input string req);
    word_len_i = wl; parity_en_i = par; stop_sel_i = st;
    clear_cnt();
    htick(n - 1);
    step();
    chk(req, NONE);
    htick(1);
    step();
    chk(req, RXTO);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: id=%b expected completion", irq_id_o);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: held in reset with the transmit-empty source enabled
    repeat (3) @(posedge clk_i);
    #2;
    chk("R1", NONE);
    rst_ni = 1'b1;
    step();
    chk("R8", THRE);

    // R7 R9 R10 R6: priority table
    for (int v = 0; v < NV; v++) begin
      {ier_i, line_err_i, thr_empty_i, modem_chg_i, rx_level_i, rx_trig_i} = VEC[v][26:4];
      step();
      chk("R7/R9/R10", VEC[v][3:0]);
    end

    // timeout tests, data below trigger
    ier_i = 4'b0001; line_err_i = 0; thr_empty_i = 0; modem_chg_i = 0;
    rx_level_i = 8'd1; rx_trig_i = 8'd8;
    run_to(2'b11, 1'b1, 2'b10, 96, "R2");
    clear_cnt();
    step();
    chk("R4", NONE);
    run_to(2'b10, 1'b0, 2'b00, 72, "R2");

    // R3 1.5 stop, with stop-centre restart mid-count
    word_len_i = 2'b00; parity_en_i = 1'b0; stop_sel_i = 2'b01;
    clear_cnt();
    htick(30);
    stop_center_i = 1'b1;
    step();
    stop_center_i = 1'b0;
    htick(59);
    step();
    chk("R4", NONE);
    htick(1);
    step();
    chk("R3", RXTO);

    run_to(2'b00, 1'b1, 2'b11, 72, "R3");

    // R5: empty FIFO never times out
    rx_level_i = 8'd0;
    htick(120);
    step();
    chk("R5", NONE);
    rx_level_i = 8'd1;
    htick(71);
    step();
    chk("R5", NONE);
    htick(1);
    step();
    chk("R5", RXTO);

    // R6: data-ready wins over timeout, both gated by ier_i[0]
    rx_level_i = 8'd8;
    step();
    chk("R6", RXD);
    rx_level_i = 8'd1;
    step();
    chk("R6", RXTO);
    ier_i = 4'b0000;
    step();
    chk("R6", NONE);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule